// File: doc/BRIEF.md
# Phase-Accumulator Step Pulse Generator

This block is a numerically controlled step-rate source for a stepper-style motor input. A wrapping phase accumulator adds a programmable increment on each clock edge. Each time the sum passes through its modulus, the accumulator's top bit goes from 1 to 0. That falling edge is caught by comparing the top bit with a one-cycle-delayed copy of itself, so no full-width comparator is needed.

The output rate is f_clk × increment / 2^W, where W is the accumulator width. The usable range runs from 0 Hz up to half the clock rate for any W. A wider accumulator only makes the frequency steps finer.

Two forms of the rate are made available. One is a single-cycle step pulse per wrap. The other is a square wave taken directly from the top bit, with a 50/50 duty cycle. A mode input chooses which of the two drives the motor output. An enable input freezes the phase without producing false steps.

Top module: `step_nco`

## Requirements
- R1: While reset is high, the accumulator clears to zero. On each rising edge with reset low and enable high, it becomes (accumulator + increment) mod 2^W.
- R2: `step_pulse` is high for exactly one cycle, in the cycle after an update that takes the accumulator's top bit (bit W-1) from 1 to 0; it is low in all other cycles.
- R3: `phase_sq` always equals the accumulator's top bit (bit W-1), so it is 0 after reset.
- R4: `motor_out` equals `step_pulse` when `sq_mode` is 0 and `phase_sq` when `sq_mode` is 1.
- R5: While enable is low, the accumulator holds its value. From the second consecutive disabled cycle onward, `step_pulse` stays low. Re-enabling produces no pulse until a real wrap occurs.
- R6: With an increment of zero, no step pulses occur and `phase_sq` holds its level.
- R7: An increment of 2^k, starting from reset, gives exactly one pulse every 2^(W-k) enabled cycles. The case k = W-1 gives the maximum rate of one pulse every two cycles, with `phase_sq` toggling every cycle.
- R8: A change on the increment input is used by the very next enabled update. The increment may change on any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accumulate enable |
| sq_mode | input | 1 | Motor output select: 0 step pulse, 1 square wave |
| step_inc | input | W | Phase increment per clock |
| step_pulse | output | 1 | One-cycle pulse per accumulator wrap |
| phase_sq | output | 1 | Accumulator top bit (square wave) |
| motor_out | output | 1 | Output selected by sq_mode |

## Verification
The assertions assume that the increment, enable and mode inputs are already synchronous to `clk` and stable around the sampling edge. Synchronising these inputs is outside the block. The bench meets this assumption by changing every input only on the falling clock edge, with reset held high from time zero. Random increments are drawn over the full W-bit range, including values at and above half the modulus. That range also covers the top-bit transitions that happen when the increment exceeds half the modulus.

// File: rtl/step_nco.sv
module step_nco #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sq_mode,
  input  logic [W-1:0] step_inc,
  output logic         step_pulse,
  output logic         phase_sq,
  output logic         motor_out
);
  localparam int TOP = W - 1;

  logic [W-1:0] phase;
  logic         top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      top_q <= 1'b0;
    end else begin
      top_q <= phase[TOP];
      if (en) phase <= phase + step_inc;
    end
  end

  assign phase_sq   = phase[TOP];
  assign step_pulse = top_q & ~phase[TOP];
  assign motor_out  = sq_mode ? phase_sq : step_pulse;
endmodule

// File: rtl/step_nco_chk.sv
module step_nco_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         sq_mode,
  input logic [W-1:0] step_inc,
  input logic [W-1:0] phase,
  input logic         step_pulse,
  input logic         phase_sq,
  input logic         motor_out
);
  AST_ACC_ADD: assert property (@(posedge clk) disable iff (rst) en |=> phase == W'($past(phase) + $past(step_inc))); // R1
  AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (rst) step_pulse |-> ($past(phase_sq) && !phase_sq)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) step_pulse |=> !step_pulse); // R2
  AST_SQ_TOP: assert property (@(posedge clk) disable iff (rst) phase_sq == phase[W-1]); // R3
  AST_SQ_ROUTE: assert property (@(posedge clk) disable iff (rst) (sq_mode && !motor_out) |-> !phase[W-1]); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(phase)); // R5
  AST_NO_FALSE_STEP: assert property (@(posedge clk) disable iff (rst) !en |=> (en || !step_pulse)); // R5
  AST_ZERO_INC: assert property (@(posedge clk) disable iff (rst) (step_inc == '0) |=> $stable(phase_sq)); // R6
endmodule

bind step_nco step_nco_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sq_mode(sq_mode), .step_inc(step_inc),
  .phase(phase), .step_pulse(step_pulse), .phase_sq(phase_sq), .motor_out(motor_out)
);

// File: tb/test_step_nco.sv
module test_step_nco;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         sq_mode = 1'b0;
  logic [W-1:0] step_inc = '0;
  logic         step_pulse, phase_sq, motor_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] m_acc = '0;
  logic         m_top = 1'b0;
  int           pulses = 0;

  always #5 clk = ~clk;

  step_nco #(.W(W)) i_step_nco (
    .clk(clk), .rst(rst), .en(en), .sq_mode(sq_mode), .step_inc(step_inc),
    .step_pulse(step_pulse), .phase_sq(phase_sq), .motor_out(motor_out)
  );

  function automatic logic exp_pulse(logic [W-1:0] a, logic t);
    return t & ~a[W-1];
  endfunction

  function automatic logic exp_motor(logic md, logic [W-1:0] a, logic t);
    return md ? a[W-1] : exp_pulse(a, t);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_acc = '0;
      m_top = 1'b0;
    end else begin
      m_top = m_acc[W-1];
      if (en) m_acc = m_acc + step_inc;
    end
    @(negedge clk);
    check("R2 step_pulse", step_pulse, exp_pulse(m_acc, m_top));
    check("R3 phase_sq", phase_sq, m_acc[W-1]);
    check("R4 motor_out", motor_out, exp_motor(sq_mode, m_acc, m_top));
    if (step_pulse) pulses++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    check("R1 reset pulse", step_pulse, 1'b0);
    check("R3 reset square", phase_sq, 1'b0);

    // R7: increment 2^12 -> one pulse every 16 cycles
    en = 1'b1; step_inc = 16'h1000; pulses = 0;
    repeat (160) step();
    check_int("R7 rate 2^12", pulses, 10);

    // R7: maximum rate, square toggles every cycle
    do_reset();
    en = 1'b1; step_inc = 16'h8000; sq_mode = 1'b1; pulses = 0;
    repeat (160) step();
    check_int("R7 max rate", pulses, 80);

    // R6: zero increment
    step_inc = '0; step(); pulses = 0;
    repeat (50) step();
    check_int("R6 zero inc pulses", pulses, 0);

    // R5: disable right after a wrap, then re-enable
    do_reset();
    sq_mode = 1'b0; en = 1'b1; step_inc = 16'h4000;
    repeat (4) step();
    en = 1'b0; step(); pulses = 0;
    repeat (10) step();
    check_int("R5 disabled no pulse", pulses, 0);
    en = 1'b1; step_inc = 16'h0001; pulses = 0;
    repeat (10) step();
    check_int("R5 reenable no false pulse", pulses, 0);

    // R8: increment change applied on next update
    do_reset();
    en = 1'b1; step_inc = 16'h7FFF; step();
    step_inc = 16'h0002; step();
    check("R8 change then wrap", step_pulse, 1'b0);
    step_inc = 16'h8000; step();
    check("R8 new inc wraps", step_pulse, 1'b1);

    // R1..R4 random mix
    for (int i = 0; i < 4000; i++) begin
      step_inc = W'($urandom);
      if ($urandom_range(0, 9) == 0) step_inc = '0;
      en = ($urandom_range(0, 4) != 0);
      sq_mode = $urandom_range(0, 1);
      rst = ($urandom_range(0, 499) == 0);
      step();
    end
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule